// File: doc/BRIEF.md
# Audio Frame Sequencer with Interrupt

This block is the low-rate timebase of a sound unit. A cycle counter walks through a looping sequence of step boundaries. At each boundary the block issues a one-cycle quarter-frame strobe, and at some boundaries a half-frame strobe as well. These strobes pace the envelope, linear-counter, length-counter and sweep logic that sits outside this block. Two step patterns are available: a four-step loop and a five-step loop with uneven half-frame spacing.

In the four-step pattern the block also raises a frame interrupt flag at the end of each loop and drives it as the level of `irq_o`. A single control write selects the pattern and sets the interrupt inhibit, and it restarts the loop. A status-read strobe clears the flag. The step boundaries are parameters. The defaults correspond to a step rate of about 240 Hz when the input clock runs at the master clock divided down to the processor cycle rate.

Top module: `frame_sequencer`

## Requirements
- R1: After reset the block is in four-step mode with inhibit clear, the flag is cleared, the cycle count is zero, and `quarter_o`, `half_o` and `irq_o` are all low.
- R2: A control write takes `ctrl_wdata_i[7]` as the mode (0 = four-step, 1 = five-step) and `ctrl_wdata_i[6]` as interrupt inhibit. Bits 5..0 are ignored.
- R3: In four-step mode `quarter_o` pulses when the count since restart reaches S1, S2, S3 and S4, and the loop repeats every S4 cycles.
- R4: In four-step mode `half_o` pulses only at the S2 and S4 boundaries.
- R5: In four-step mode with inhibit clear, the flag is set on the S4 cycle and on the two cycles after it. `irq_o` shows the flag one cycle later. A set in the same cycle as a status read wins. With inhibit set, the flag is never set.
- R6: In five-step mode `quarter_o` pulses at S1..S4 and `half_o` pulses at S1 and S3. S5 gives no strobe, and the loop repeats every S5 cycles.
- R7: The flag is never set while five-step mode is selected.
- R8: A control write with bit 6 set clears the flag. A write with bit 6 clear leaves it unchanged.
- R9: `stat_rd_i` clears the flag when no set condition is present in that cycle.
- R10: A control write restarts the count at zero, so the first regular step comes S1 cycles after the write edge. A write selecting five-step mode also gives one `quarter_o` and `half_o` pulse in the cycle right after the write.
- R11: Strobes last a single cycle, and `half_o` is never high without `quarter_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Cycle clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control data: bit 7 mode, bit 6 inhibit |
| stat_rd_i | input | 1 | Status read, clears the frame flag |
| quarter_o | output | 1 | Quarter-frame strobe |
| half_o | output | 1 | Half-frame strobe |
| irq_o | output | 1 | Frame interrupt level |

## Verification
The assertions check on every cycle that a half-frame strobe always comes with a quarter-frame strobe. They also check that the interrupt never rises in five-step mode, that an inhibiting write clears it, and that a five-step write gives an immediate double strobe. Only the bench's scenarios can show the exact step boundaries of both patterns, the three-cycle set window and its priority over a status read, and the restart delay after a write. The bench shows these by comparing every cycle against a behavioural model and by counting pulses over whole loops.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;
  typedef enum logic {
    SEQ_FOUR = 1'b0,
    SEQ_FIVE = 1'b1
  } seq_mode_e;

  localparam int unsigned CTRL_W        = 8;
  localparam int unsigned CTRL_MODE_BIT = 7;
  localparam int unsigned CTRL_INH_BIT  = 6;
  localparam int unsigned NUM_BOUNDS    = 5;

  // step masks, bit k = boundary k+1
  localparam logic [NUM_BOUNDS-1:0] Q_MASK_FOUR = 5'b01111;
  localparam logic [NUM_BOUNDS-1:0] H_MASK_FOUR = 5'b01010;
  localparam logic [NUM_BOUNDS-1:0] Q_MASK_FIVE = 5'b01111;
  localparam logic [NUM_BOUNDS-1:0] H_MASK_FIVE = 5'b00101;
endpackage

// File: rtl/frame_step_cnt.sv
module frame_step_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] wrap_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (cnt_q == wrap_i) begin
      cnt_q <= CNT_W'(1);
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/frame_step_decode.sv
module frame_step_decode
  import frame_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned S1    = 7459,
  parameter int unsigned S2    = 14915,
  parameter int unsigned S3    = 22373,
  parameter int unsigned S4    = 29830,
  parameter int unsigned S5    = 37287
) (
  input  seq_mode_e        mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             quarter_o,
  output logic             half_o,
  output logic             loop_end_o,
  output logic [CNT_W-1:0] wrap_o
);
  localparam logic [CNT_W-1:0] BOUND [NUM_BOUNDS] = '{
    CNT_W'(S1), CNT_W'(S2), CNT_W'(S3), CNT_W'(S4), CNT_W'(S5)
  };

  logic [NUM_BOUNDS-1:0] hit;
  logic [NUM_BOUNDS-1:0] q_mask, h_mask;

  for (genvar k = 0; k < NUM_BOUNDS; k++) begin : g_hit
    assign hit[k] = (cnt_i == BOUND[k]);
  end

  always_comb begin
    if (mode_i == SEQ_FIVE) begin
      q_mask = Q_MASK_FIVE;
      h_mask = H_MASK_FIVE;
      wrap_o = BOUND[4];
    end else begin
      q_mask = Q_MASK_FOUR;
      h_mask = H_MASK_FOUR;
      wrap_o = BOUND[3];
    end
  end

  assign quarter_o  = |(hit & q_mask);
  assign half_o     = |(hit & h_mask);
  assign loop_end_o = (mode_i == SEQ_FOUR) && hit[3];
endmodule

// File: rtl/frame_irq_flag.sv
module frame_irq_flag #(
  parameter int unsigned TAIL = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic restart_i,
  input  logic wr_clr_i,
  input  logic rd_clr_i,
  output logic flag_o
);
  logic [TAIL-1:0] tail_q;
  logic [TAIL:0]   tail_d;
  logic            set_now;
  logic            flag_q;

  assign tail_d  = {tail_q, arm_i};
  assign set_now = arm_i || (|tail_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tail_q <= '0;
    end else if (restart_i) begin
      tail_q <= '0;
    end else begin
      tail_q <= tail_d[TAIL-1:0];
    end
  end

  // write clear > set > read clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (wr_clr_i) begin
      flag_q <= 1'b0;
    end else if (set_now) begin
      flag_q <= 1'b1;
    end else if (rd_clr_i) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
  import frame_seq_pkg::*;
#(
  parameter int unsigned S1       = 7459,
  parameter int unsigned S2       = 14915,
  parameter int unsigned S3       = 22373,
  parameter int unsigned S4       = 29830,
  parameter int unsigned S5       = S4 + (S4 - S3),
  parameter int unsigned IRQ_TAIL = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              stat_rd_i,
  output logic              quarter_o,
  output logic              half_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = $clog2(S5 + 1);

  seq_mode_e        mode_q;
  logic             inh_q;
  logic             imm_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] wrap;
  logic             dec_q, dec_h, loop_end;
  logic             arm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= SEQ_FOUR;
      inh_q  <= 1'b0;
      imm_q  <= 1'b0;
    end else begin
      imm_q <= ctrl_we_i && ctrl_wdata_i[CTRL_MODE_BIT];
      if (ctrl_we_i) begin
        mode_q <= seq_mode_e'(ctrl_wdata_i[CTRL_MODE_BIT]);
        inh_q  <= ctrl_wdata_i[CTRL_INH_BIT];
      end
    end
  end

  frame_step_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(ctrl_we_i),
    .wrap_i   (wrap),
    .cnt_o    (cnt)
  );

  frame_step_decode #(
    .CNT_W(CNT_W), .S1(S1), .S2(S2), .S3(S3), .S4(S4), .S5(S5)
  ) i_dec (
    .mode_i    (mode_q),
    .cnt_i     (cnt),
    .quarter_o (dec_q),
    .half_o    (dec_h),
    .loop_end_o(loop_end),
    .wrap_o    (wrap)
  );

  assign arm = loop_end && !inh_q;

  frame_irq_flag #(.TAIL(IRQ_TAIL)) i_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (arm),
    .restart_i(ctrl_we_i),
    .wr_clr_i (ctrl_we_i && ctrl_wdata_i[CTRL_INH_BIT]),
    .rd_clr_i (stat_rd_i),
    .flag_o   (irq_o)
  );

  // immediate step after a five-step write
  assign quarter_o = dec_q || imm_q;
  assign half_o    = dec_h || imm_q;
endmodule

// File: rtl/frame_sequencer_chk.sv
module frame_sequencer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ctrl_we_i,
  input logic [7:0] ctrl_wdata_i,
  input logic       quarter_o,
  input logic       half_o,
  input logic       irq_o,
  input logic       five_mode_i
);
  // R11
  half_has_quarter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_o |-> quarter_o);

  // R7
  five_no_irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    five_mode_i |=> !$rose(irq_o));

  // R5
  irq_rise_four_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !$past(five_mode_i));

  // R8
  inh_write_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_wdata_i[6]) |=> !irq_o);

  // R10
  five_write_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_wdata_i[7]) |=> (quarter_o && half_o));
endmodule

bind frame_sequencer frame_sequencer_chk i_frame_sequencer_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_we_i   (ctrl_we_i),
  .ctrl_wdata_i(ctrl_wdata_i),
  .quarter_o   (quarter_o),
  .half_o      (half_o),
  .irq_o       (irq_o),
  .five_mode_i (mode_q == frame_seq_pkg::SEQ_FIVE)
);

// File: tb/test_frame_sequencer.sv
module test_frame_sequencer;
  localparam int P1 = 7, P2 = 15, P3 = 22, P4 = 30, P5 = 37;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctrl_we_i = 1'b0;
  logic [7:0] ctrl_wdata_i = 8'h00;
  logic       stat_rd_i = 1'b0;
  logic       quarter_o, half_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit sb_on = 1'b0;
  bit done = 1'b0;

  frame_sequencer #(.S1(P1), .S2(P2), .S3(P3), .S4(P4), .S5(P5)) i_frame_sequencer (
    .clk_i, .rst_ni, .ctrl_we_i, .ctrl_wdata_i, .stat_rd_i,
    .quarter_o, .half_o, .irq_o
  );

  always #2 clk_i = ~clk_i;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_cnt, m_tail;
  bit m_five, m_inh, m_flag, m_imm;

  function automatic bit at_step(input int c, input int k);
    int b[5] = '{P1, P2, P3, P4, P5};
    return c == b[k-1];
  endfunction

  function automatic bit exp_q();
    return m_imm || at_step(m_cnt, 1) || at_step(m_cnt, 2) || at_step(m_cnt, 3) || at_step(m_cnt, 4);
  endfunction

  function automatic bit exp_h();
    if (m_imm) return 1'b1;
    if (m_five) return at_step(m_cnt, 1) || at_step(m_cnt, 3);
    return at_step(m_cnt, 2) || at_step(m_cnt, 4);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_tail = 0; m_five = 0; m_inh = 0; m_flag = 0; m_imm = 0;
    end else begin
      bit setc;
      setc = !m_five && !m_inh && (m_cnt == P4 || m_tail > 0);
      if (ctrl_we_i && ctrl_wdata_i[6]) m_flag = 0;
      else if (setc) m_flag = 1;
      else if (stat_rd_i) m_flag = 0;
      if (ctrl_we_i) begin
        m_five = ctrl_wdata_i[7];
        m_inh  = ctrl_wdata_i[6];
        m_imm  = ctrl_wdata_i[7];
        m_cnt  = 0;
        m_tail = 0;
      end else begin
        m_imm  = 0;
        m_tail = (!m_five && m_cnt == P4) ? 2 : (m_tail > 0 ? m_tail - 1 : 0);
        m_cnt  = (m_cnt == (m_five ? P5 : P4)) ? 1 : m_cnt + 1;
      end
    end
  end

  bit prev_q = 1'b0;
  always @(negedge clk_i) begin
    if (sb_on && rst_ni) begin
      check(quarter_o == exp_q(), "R3/R6 quarter", quarter_o, exp_q());
      check(half_o == exp_h(), "R4/R6 half", half_o, exp_h());
      check(irq_o == m_flag, "R5/R7 irq", irq_o, m_flag);
      // R11 quarter never holds two cycles in these settings
      check(!(prev_q && quarter_o && !m_imm), "R11 single-cycle", quarter_o, 0);
    end
    prev_q = quarter_o;
  end

  task automatic do_write(input logic [7:0] d);
    @(negedge clk_i); ctrl_we_i = 1'b1; ctrl_wdata_i = d;
    @(negedge clk_i); ctrl_we_i = 1'b0; ctrl_wdata_i = 8'h00;
  endtask

  task automatic do_read();
    @(negedge clk_i); stat_rd_i = 1'b1;
    @(negedge clk_i); stat_rd_i = 1'b0;
  endtask

  task automatic count_pulses(input int n, output int q, output int h, output int irqs);
    q = 0; h = 0; irqs = 0;
    repeat (n) begin
      @(negedge clk_i);
      q += int'(quarter_o); h += int'(half_o); irqs += int'(irq_o);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int q, h, s, first;
    repeat (3) @(negedge clk_i);
    check(!quarter_o && !half_o && !irq_o, "R1 reset outputs", {quarter_o, half_o, irq_o}, 0);
    rst_ni = 1'b1;
    sb_on  = 1'b1;
    check(!quarter_o && !half_o && !irq_o, "R1 after release", {quarter_o, half_o, irq_o}, 0);

    count_pulses(P4, q, h, s);
    check(q == 4, "R3 quarter per loop", q, 4);
    check(h == 2, "R4 half per loop", h, 2);
    @(negedge clk_i);
    check(irq_o == 1'b1, "R5 flag at loop end", irq_o, 1);
    do_read();
    check(irq_o == 1'b1, "R5 set beats read", irq_o, 1);
    do_read();
    check(irq_o == 1'b0, "R9 read clears", irq_o, 0);

    first = 0;
    for (int k = 1; k <= 2 * P4 && first == 0; k++) begin
      @(negedge clk_i);
      if (irq_o) first = k;
    end
    check(first != 0, "R5 flag sets again", first, 1);
    do_write(8'h3F);
    check(irq_o == 1'b1, "R8 R2 write w/o inhibit keeps flag", irq_o, 1);
    do_write(8'h40);
    check(irq_o == 1'b0, "R8 inhibit write clears", irq_o, 0);
    count_pulses(2 * P4 + 5, q, h, s);
    check(s == 0, "R5 inhibit blocks set", s, 0);
    check(q == 8, "R3 quarter two loops", q, 8);

    do_write(8'h00);
    first = 0;
    for (int k = 1; k <= P4 && first == 0; k++) begin
      @(negedge clk_i);
      if (quarter_o) first = k;
    end
    check(first == P1, "R10 restart delay", first, P1);

    do_write(8'h80);
    check(quarter_o && half_o, "R10 immediate five-step strobe", {quarter_o, half_o}, 3);
    count_pulses(P5, q, h, s);
    check(q == 4, "R6 quarter per five loop", q, 4);
    check(h == 2, "R6 half per five loop", h, 2);
    count_pulses(3 * P5, q, h, s);
    check(s == 0, "R7 no flag in five-step", s, 0);
    check(q == 12 && h == 6, "R6 five-step repeats", q, 12);

    do_write(8'hC0);
    check(quarter_o && half_o && !irq_o, "R2 mode and inhibit together", quarter_o, 1);
    count_pulses(P5, q, h, s);
    check(q == 4 && s == 0, "R6 five-step inhibited", q, 4);

    do_write(8'h00);
    check(!quarter_o, "R10 four-step write no immediate strobe", quarter_o, 0);
    count_pulses(P4 + 2, q, h, s);
    check(irq_o == 1'b1, "R5 flag after restart loop", irq_o, 1);

    repeat (4) @(negedge clk_i);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule